// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counting Timer

This block is a register-mapped timer with several independent channels. Each channel has a 32-bit counter that counts down, a 32-bit reload register, and a 16-bit control register. The counter steps down once per prescaled tick of the peripheral clock. When a tick arrives while the counter is zero, the counter loads the reload value and a sticky underflow flag is set. The counter does not wrap past zero. Each channel drives one interrupt line, which is the flag gated by an enable bit.

A single shared start byte holds one run bit per channel. Software starts or halts a channel by setting or clearing its bit. While a channel is halted, software can set a new start value by writing the counter and a new period by writing the reload register. To read elapsed time, start the counter from all ones and read its inverted value. To get periodic events, load the same value into the reload register and the counter.

Top module: `rtmr_top`

## Requirements
- R1: After synchronous reset, every register reads 0, every run bit is 0 and every interrupt output is low.
- R2: Byte addresses (bits 1:0 ignored): the start register is at 4. Channel n occupies 8+12n (reload), 12+12n (counter) and 16+12n (control). Any other address reads 0, and writes to it change nothing.
- R3: Start register bit n runs channel n while set. Reading the start register returns the run bits, and bits at or above the channel count read 0. A halted channel's counter holds its value.
- R4: Control bits 2:0 set the tick period in clock cycles: 0 gives 4, 1 gives 16, 2 gives 64, 3 gives 256, and 4 to 7 give 1024.
- R5: The counter decreases by exactly one per tick. A counter started from all ones reads the bitwise inverse of the number of elapsed ticks.
- R6: A tick while the counter is 0 loads the reload value and sets the flag in control bit 8. A counter written to C and then started underflows div*(C+1) cycles after the clock edge that sets its run bit.
- R7: The flag is sticky. Writing control with bit 8 = 0 clears it. Writing bit 8 = 1 leaves it unchanged, whether it is set or clear.
- R8: The interrupt output of a channel is high exactly when its flag and its enable (control bit 5) are both set.
- R9: The prescaler phase of a channel restarts when its run bit goes from 0 to 1. A partial tick from an earlier run does not shorten the next period.
- R10: Control bits other than 8, 5 and 2:0 read 0, whatever was written to them.
- R11: A counter write takes effect immediately as the new start value. The reload register sets the period of every later cycle: after the first underflow, underflows repeat every div*(R+1) cycles.
- R12: Channels are independent. Running or underflowing one channel does not change another channel's interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr (combinational) |
| irq | output | N_CH | One underflow interrupt per channel |

## Verification
The main sweep covers every channel and all eight prescaler codes. Each case uses a fixed start value and reload, and the bench measures the cycle count from the start edge to the interrupt. A wrong divisor, an off-by-one in the underflow point, or a miswired channel each gives a different count. Further runs cover the following:
- a free-running count from all ones that is then halted, which separates elapsed-tick counting from hold behaviour;
- a restart after a partial prescaler period, which exposes any stale phase;
- a second underflow measured from a flag clear, which separates the reload path from the counter write path;
- flag and enable combinations, which show that the interrupt needs both bits.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

    localparam int unsigned PRE_W        = 10;
    localparam int unsigned START_WORD   = 1;
    localparam int unsigned CH_WORD0     = 2;
    localparam int unsigned WORDS_PER_CH = 3;
    localparam int unsigned FLAG_BIT     = 8;
    localparam int unsigned IE_BIT       = 5;

    typedef logic [2:0] presc_t;

    typedef struct packed {
        logic   flag;
        logic   irq_en;
        presc_t presc;
    } ctl_t;

    // terminal value of the prescale counter: divisor minus one
    function automatic logic [PRE_W-1:0] presc_limit(input presc_t sel);
        int unsigned d;
        d = (sel > 3'd4) ? 1024 : (4 << (2 * int'(sel)));
        return PRE_W'(d - 1);
    endfunction

    function automatic logic [15:0] ctl_pack(input ctl_t c);
        logic [15:0] r;
        r           = '0;
        r[FLAG_BIT] = c.flag;
        r[IE_BIT]   = c.irq_en;
        r[2:0]      = c.presc;
        return r;
    endfunction

endpackage

// File: rtl/rtmr_prescale.sv
module rtmr_prescale
    import rtmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  presc_t presc,
    output logic   tick
);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] lim;

    assign lim  = presc_limit(presc);
    // >= so that a divisor lowered mid-period cannot strand the counter
    assign tick = run && (pre_cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
        end else if (pre_cnt >= lim) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    a_r9_phase_restart: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (pre_cnt == '0));

    a_r4_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/rtmr_channel.sv
module rtmr_channel
    import rtmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wr_reload,
    input  logic             wr_count,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] count_q,
    output logic [15:0]      ctrl_rd,
    output logic             irq
);

    ctl_t ctl;
    logic tick;
    logic underflow;

    rtmr_prescale u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .presc (ctl.presc),
        .tick  (tick)
    );

    // a counter write in the same cycle takes precedence over the tick
    assign underflow = tick && (count_q == '0) && !wr_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else if (wr_reload) begin
            reload_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (wr_count) begin
            count_q <= wdata;
        end else if (tick) begin
            count_q <= (count_q == '0) ? reload_q : count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctl.presc  <= wdata[2:0];
                ctl.irq_en <= wdata[IE_BIT];
                ctl.flag   <= ctl.flag & wdata[FLAG_BIT];
            end
            if (underflow) begin
                ctl.flag <= 1'b1;
            end
        end
    end

    assign ctrl_rd = ctl_pack(ctl);
    assign irq     = ctl.flag & ctl.irq_en;

    a_r6_underflow_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q == '0 && !wr_count) |=> (count_q == $past(reload_q) && ctl.flag));

    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q != '0 && !wr_count) |=> (count_q == $past(count_q) - 1'b1));

    a_r3_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_count) |=> $stable(count_q));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctl.flag && !wr_ctrl) |=> ctl.flag);

endmodule

// File: rtl/rtmr_top.sv
module rtmr_top
    import rtmr_pkg::*;
#(
    parameter int unsigned N_CH   = 3,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [N_CH-1:0]   irq
);

    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              start_hit;
    logic [N_CH-1:0]   run_q;
    logic [N_CH-1:0]   hit_rel, hit_cnt, hit_ctl;
    logic [CNT_W-1:0]  rel_rd [N_CH];
    logic [CNT_W-1:0]  cnt_rd [N_CH];
    logic [15:0]       ctl_rd [N_CH];

    assign word      = bus_addr[ADDR_W-1:2];
    assign start_hit = (word == WORD_W'(START_WORD));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (bus_we && start_hit) begin
            run_q <= bus_wdata[N_CH-1:0];
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        localparam int unsigned BASE = CH_WORD0 + WORDS_PER_CH * g;

        assign hit_rel[g] = (word == WORD_W'(BASE));
        assign hit_cnt[g] = (word == WORD_W'(BASE + 1));
        assign hit_ctl[g] = (word == WORD_W'(BASE + 2));

        rtmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .run       (run_q[g]),
            .wr_reload (bus_we && hit_rel[g]),
            .wr_count  (bus_we && hit_cnt[g]),
            .wr_ctrl   (bus_we && hit_ctl[g]),
            .wdata     (bus_wdata),
            .reload_q  (rel_rd[g]),
            .count_q   (cnt_rd[g]),
            .ctrl_rd   (ctl_rd[g]),
            .irq       (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (start_hit) begin
            bus_rdata[N_CH-1:0] = run_q;
        end
        for (int i = 0; i < N_CH; i++) begin
            if (hit_rel[i]) bus_rdata = rel_rd[i];
            if (hit_cnt[i]) bus_rdata = cnt_rd[i];
            if (hit_ctl[i]) bus_rdata = CNT_W'(ctl_rd[i]);
        end
    end

    a_r2_decode_unique: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_hit, hit_rel, hit_cnt, hit_ctl}));

endmodule

// File: tb/tb_rtmr_top.sv
`timescale 1ns/100ps
module tb_rtmr_top;

    localparam int N_CH = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N_CH-1:0] irq;

    int total = 0;
    int failed = 0;

    rtmr_top #(.N_CH(N_CH), .ADDR_W(8), .CNT_W(32)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic int divisor(input int sel);
        return (sel >= 4) ? 1024 : (4 << (2 * sel));
    endfunction

    function automatic logic [7:0] reg_addr(input int ch, input int sub);
        return 8'(8 + 12 * ch + 4 * sub);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic measure(input int ch, output int k);
        k = 0;
        while (!irq[ch] && k < 20000) begin
            @(posedge clk);
            #1;
            k++;
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - failed, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int k;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int ch = 0; ch < N_CH; ch++) begin
            for (int s = 0; s < 3; s++) begin
                rd(reg_addr(ch, s), v);
                chk("R1 register after reset", v, 32'h0);
            end
        end
        rd(8'd4, v);
        chk("R1 start after reset", v, 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // R2: unmapped addresses
        wr(8'd0, 32'hFFFF_FFFF);
        rd(8'd0, v);
        chk("R2 unmapped read", v, 32'h0);
        rd(8'd4, v);
        chk("R2 unmapped write leaves start", v, 32'h0);
        rd(reg_addr(N_CH, 0), v);
        chk("R2 beyond last channel", v, 32'h0);

        // R3: start readback masks unused bits
        wr(8'd4, 32'hFF);
        rd(8'd4, v);
        chk("R3 start readback", v, 32'h7);
        wr(8'd4, 32'h0);

        // R10: reserved control bits
        wr(reg_addr(0, 2), 32'h0000_FFFF);
        rd(reg_addr(0, 2), v);
        chk("R10 reserved bits", v, 32'h0000_0027);

        // R4, R6, R12: sweep channels and prescaler codes
        for (int ch = 0; ch < N_CH; ch++) begin
            for (int sel = 0; sel < 8; sel++) begin
                wr(reg_addr(ch, 2), 32'(sel) | 32'h20);
                wr(reg_addr(ch, 1), 32'd2);
                wr(reg_addr(ch, 0), 32'd5);
                wr(8'd4, 32'(1 << ch));
                measure(ch, k);
                chk("R4 R6 underflow time", 32'(k), 32'(divisor(sel) * 3));
                rd(reg_addr(ch, 1), v);
                chk("R6 reload after underflow", v, 32'd5);
                chk("R12 other irqs quiet", 32'(irq & ~(3'(1) << ch)), 32'h0);
                wr(8'd4, 32'h0);
                wr(reg_addr(ch, 2), 32'h0);
            end
        end

        // R5, R3: elapsed count from all ones, then hold
        wr(reg_addr(1, 2), 32'h0);
        wr(reg_addr(1, 1), 32'hFFFF_FFFF);
        wr(8'd4, 32'h2);
        repeat (39) @(posedge clk);
        wr(8'd4, 32'h0);
        rd(reg_addr(1, 1), v);
        chk("R5 inverted elapsed", v, ~32'd10);
        repeat (50) @(posedge clk);
        rd(reg_addr(1, 1), v);
        chk("R3 halted counter holds", v, ~32'd10);

        // R7: flag sticky behaviour
        wr(reg_addr(0, 2), 32'h20);
        wr(reg_addr(0, 1), 32'h0);
        wr(8'd4, 32'h1);
        measure(0, k);
        chk("R6 underflow from zero", 32'(k), 32'd4);
        wr(8'd4, 32'h0);
        wr(reg_addr(0, 2), 32'h120);
        rd(reg_addr(0, 2), v);
        chk("R7 write one keeps flag", v, 32'h120);
        wr(reg_addr(0, 2), 32'h20);
        rd(reg_addr(0, 2), v);
        chk("R7 write zero clears flag", v, 32'h20);
        chk("R8 irq low after clear", 32'(irq[0]), 32'h0);
        wr(reg_addr(0, 2), 32'h100);
        rd(reg_addr(0, 2), v);
        chk("R7 write one does not set", v, 32'h0);

        // R8: interrupt needs enable
        wr(reg_addr(2, 2), 32'h0);
        wr(reg_addr(2, 1), 32'h0);
        wr(8'd4, 32'h4);
        repeat (10) @(posedge clk);
        #1;
        rd(reg_addr(2, 2), v);
        chk("R8 flag set with enable off", v, 32'h100);
        chk("R8 irq low without enable", 32'(irq[2]), 32'h0);
        wr(reg_addr(2, 2), 32'h120);
        chk("R8 irq high with enable", 32'(irq[2]), 32'h1);
        wr(8'd4, 32'h0);
        wr(reg_addr(2, 2), 32'h0);

        // R9: prescaler phase restarts
        wr(reg_addr(1, 2), 32'h21);
        wr(reg_addr(1, 1), 32'd1);
        wr(8'd4, 32'h2);
        repeat (9) @(posedge clk);
        wr(8'd4, 32'h0);
        wr(reg_addr(1, 1), 32'd1);
        wr(8'd4, 32'h2);
        measure(1, k);
        chk("R9 full period after restart", 32'(k), 32'd32);
        wr(8'd4, 32'h0);
        wr(reg_addr(1, 2), 32'h0);

        // R11: reload sets later periods
        wr(reg_addr(0, 2), 32'h20);
        wr(reg_addr(0, 1), 32'd0);
        wr(reg_addr(0, 0), 32'd7);
        wr(8'd4, 32'h1);
        measure(0, k);
        chk("R11 first underflow", 32'(k), 32'd4);
        rd(reg_addr(0, 1), v);
        chk("R11 counter loaded from reload", v, 32'd7);
        wr(reg_addr(0, 2), 32'h20);
        measure(0, k);
        chk("R11 periodic interval", 32'(k), 32'd31);
        wr(8'd4, 32'h0);

        summary();
        $finish;
    end

endmodule